// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Parity Encoder

This block is a streaming systematic encoder for quasi-cyclic irregular repeat-accumulate LDPC codes. A message arrives serially, one bit per valid cycle, framed by start and end strobes. A frame-type bit and a code-rate index travel with the start strobe. The block stores the whole message in a group-organised buffer.

After the end strobe, the block clears a parity memory. It then walks a table of entries for the selected configuration. Each entry names a message group, a rotation amount and a parity word. The group is rotated, XORed into that word, and written back to the same word.

The codeword then leaves serially: first the message bits unchanged, then the parity bits. Each parity bit is formed by a running XOR over the accumulated bits, visited in codeword order. The group width and all tables are parameters, so a small configuration can stand in for the full-size tables.

Top module: `qc_ldpc_encoder`

## Requirements
- R1: Frame type and rate index are taken only on the cycle where `in_vld` and `in_sof` are both high. Changes on those inputs later in the frame have no effect on the codeword.
- R2: No codeword bit appears before the input end strobe. Encoding begins only once the whole message is stored.
- R3: For every table entry of the selected configuration, message group `g` is rotated by the entry's shift. The result is XORed into parity word `a` and written back to word `a`.
- R4: The rotation accepts any shift from 0 to P-1 and is built as log2(P) power-of-two stages. Input bit `i` of a group lands in position `(i+s) mod P`. Message bit `n` belongs to group `n/P`, position `n mod P`.
- R5: With Q parity words, parity index `j` is held in word `j mod Q`, position `j / Q`. Output parity bit `p_j` equals the accumulated bit `j` XOR `p_(j-1)`, where `p_(-1)` is 0.
- R6: The output carries the K message bits first, in arrival order, then the Q*P parity bits, one bit per cycle with no gaps.
- R7: `out_sof` is high only with the first codeword bit and `out_eof` only with the last. `out_vld` is high on every codeword bit.
- R8: The parity memory is zeroed at the start of every encode, so a frame's parity does not depend on earlier frames.
- R9: `busy` is high from the cycle after an accepted start until the cycle in which `out_eof` is shown, when it is low. A start arriving while `busy` is high is ignored.
- R10: A start whose combination is invalid is rejected: no frame is produced, `busy` stays low, and `cfg_err` pulses for exactly one cycle after it. Frame type 0 is the long frame and 1 the short frame. A combination is invalid when the rate index is at least NRATE, or when the frame is short and the rate index is NRATE-1.
- R11: During reset, `out_vld`, `out_sof`, `out_eof`, `busy` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Serial message bit |
| in_vld | input | 1 | Input bit qualifier |
| in_sof | input | 1 | First message bit marker |
| in_eof | input | 1 | Last message bit marker |
| in_ftype | input | 1 | Frame type (0 long, 1 short) |
| in_rate | input | RATE_W | Code-rate index |
| out_bit | output | 1 | Serial codeword bit |
| out_vld | output | 1 | Output bit qualifier |
| out_sof | output | 1 | First codeword bit marker |
| out_eof | output | 1 | Last codeword bit marker |
| busy | output | 1 | Frame in progress; new starts ignored |
| cfg_err | output | 1 | One-cycle pulse on a rejected start |

## Verification
Some properties are checked on every cycle. These are the pairing of the output strobes with `out_vld`, and the fact that `busy` covers every output bit but the last. Others are that the captured configuration stays stable while busy, that `cfg_err` only follows a start seen while idle, and that the parity memory reads zero after a clear. In the rotator, a zero shift must pass a group through unchanged, and every rotation must preserve the number of set bits.

The actual codeword values can only be shown by the bench's scenarios. These include the rotate-and-accumulate placement, the running XOR order, and the message-first ordering. They also include that frame and rate changes in mid-frame, and starts issued during output, leave a frame untouched. The bench compares each output bit against a behavioural golden model across every valid configuration and several message patterns, including back-to-back encodes that expose stale parity.

// File: rtl/qc_enc_pkg.sv
`timescale 1ns/1ps
package qc_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CLR,
        ST_ACC,
        ST_EMIT
    } qc_state_e;

    typedef struct packed {
        logic dat;
        logic vld;
        logic sof;
        logic eof;
    } qc_out_t;

    // Legal frame-type and rate pairing
    function automatic logic qc_cfg_ok(input logic ftype, input int unsigned rate,
                                       input int unsigned nrate);
        return (rate < nrate) && !(ftype && (rate == nrate - 1));
    endfunction

endpackage

// File: rtl/qc_rotator.sv
`timescale 1ns/1ps
module qc_rotator #(
    parameter int P    = 8,
    parameter int SH_W = 3
) (
    input  logic [P-1:0]    din,
    input  logic [SH_W-1:0] shift,
    output logic [P-1:0]    dout
);

    // Stage k moves every bit up by 2**k places (mod P) when shift bit k is set
    always_comb begin
        logic [P-1:0] cur;
        logic [P-1:0] nxt;
        cur = din;
        for (int k = 0; k < SH_W; k++) begin
            nxt = cur;
            if (shift[k]) begin
                for (int i = 0; i < P; i++) begin
                    nxt[(i + (1 << k)) % P] = cur[i];
                end
            end
            cur = nxt;
        end
        dout = cur;

        // R4
        zero_shift_chk: assert ((shift != '0) || (dout == din));
        // R4
        weight_keep_chk: assert ($countones(dout) == $countones(din));
    end

endmodule

// File: rtl/qc_msg_buffer.sv
`timescale 1ns/1ps
module qc_msg_buffer #(
    parameter int P        = 8,
    parameter int MAX_KGRP = 4,
    parameter int KG_W     = 2,
    parameter int SH_W     = 3
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [KG_W-1:0] wr_grp,
    input  logic [SH_W-1:0] wr_pos,
    input  logic            wr_bit,
    input  logic [KG_W-1:0] grp_addr,
    output logic [P-1:0]    grp_word,
    input  logic [KG_W-1:0] bit_grp,
    input  logic [SH_W-1:0] bit_pos,
    output logic            bit_out
);

    logic [P-1:0] mem [MAX_KGRP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_grp][wr_pos] <= wr_bit;
        end
    end

    assign grp_word = mem[grp_addr];
    assign bit_out  = mem[bit_grp][bit_pos];

endmodule

// File: rtl/qc_parity_store.sv
`timescale 1ns/1ps
module qc_parity_store #(
    parameter int P        = 8,
    parameter int MAX_QGRP = 3,
    parameter int QG_W     = 2,
    parameter int SH_W     = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            acc_en,
    input  logic [QG_W-1:0] acc_addr,
    input  logic [P-1:0]    acc_data,
    input  logic [QG_W-1:0] rd_word,
    input  logic [SH_W-1:0] rd_pos,
    output logic            rd_bit
);

    logic [P-1:0] words [MAX_QGRP];
    logic         any_set;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int w = 0; w < MAX_QGRP; w++) begin
                words[w] <= '0;
            end
        end else if (acc_en) begin
            words[acc_addr] <= words[acc_addr] ^ acc_data;
        end
    end

    assign rd_bit = words[rd_word][rd_pos];

    always_comb begin
        any_set = 1'b0;
        for (int w = 0; w < MAX_QGRP; w++) begin
            any_set = any_set | (|words[w]);
        end
    end

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any_set);

    // R3
    acc_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> (int'(acc_addr) < MAX_QGRP));

endmodule

// File: rtl/qc_code_tables.sv
`timescale 1ns/1ps
module qc_code_tables #(
    parameter int RATE_W = 2,
    parameter int NENT   = 18,
    parameter int KG_W   = 2,
    parameter int QG_W   = 2,
    parameter int SH_W   = 3,
    parameter int EN_W   = 5,
    parameter int unsigned CFG_KGRP  [2**(RATE_W+1)] = '{default: 0},
    parameter int unsigned CFG_BASE  [2**(RATE_W+1)] = '{default: 0},
    parameter int unsigned CFG_CNT   [2**(RATE_W+1)] = '{default: 0},
    parameter int unsigned FT_QGRP   [2]             = '{default: 0},
    parameter int unsigned ENT_GRP   [NENT]          = '{default: 0},
    parameter int unsigned ENT_SHIFT [NENT]          = '{default: 0},
    parameter int unsigned ENT_ADDR  [NENT]          = '{default: 0}
) (
    input  logic [RATE_W:0] cfg_idx,
    input  logic [EN_W-1:0] ent_idx,
    output logic [KG_W:0]   kgrp,
    output logic [QG_W:0]   qgrp,
    output logic [EN_W-1:0] base,
    output logic [EN_W:0]   cnt,
    output logic [KG_W-1:0] e_grp,
    output logic [SH_W-1:0] e_shift,
    output logic [QG_W-1:0] e_addr
);

    localparam int NCFG = 2**(RATE_W+1);

    logic [KG_W:0]   kg_lut [NCFG];
    logic [EN_W-1:0] bs_lut [NCFG];
    logic [EN_W:0]   ct_lut [NCFG];
    logic [QG_W:0]   qg_lut [2];
    logic [KG_W-1:0] eg_lut [NENT];
    logic [SH_W-1:0] es_lut [NENT];
    logic [QG_W-1:0] ea_lut [NENT];

    for (genvar c = 0; c < NCFG; c++) begin : g_cfg
        assign kg_lut[c] = (KG_W+1)'(CFG_KGRP[c]);
        assign bs_lut[c] = EN_W'(CFG_BASE[c]);
        assign ct_lut[c] = (EN_W+1)'(CFG_CNT[c]);
    end

    for (genvar f = 0; f < 2; f++) begin : g_ft
        assign qg_lut[f] = (QG_W+1)'(FT_QGRP[f]);
    end

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        assign eg_lut[e] = KG_W'(ENT_GRP[e]);
        assign es_lut[e] = SH_W'(ENT_SHIFT[e]);
        assign ea_lut[e] = QG_W'(ENT_ADDR[e]);
    end

    assign kgrp    = kg_lut[cfg_idx];
    assign base    = bs_lut[cfg_idx];
    assign cnt     = ct_lut[cfg_idx];
    assign qgrp    = qg_lut[cfg_idx[RATE_W]];
    assign e_grp   = eg_lut[ent_idx];
    assign e_shift = es_lut[ent_idx];
    assign e_addr  = ea_lut[ent_idx];

endmodule

// File: rtl/qc_ldpc_encoder.sv
`timescale 1ns/1ps
module qc_ldpc_encoder
    import qc_enc_pkg::*;
#(
    parameter int P        = 8,
    parameter int MAX_KGRP = 4,
    parameter int MAX_QGRP = 3,
    parameter int RATE_W   = 2,
    parameter int NRATE    = 3,
    parameter int NENT     = 18,
    parameter int unsigned CFG_KGRP  [2**(RATE_W+1)] = '{2, 3, 4, 0, 2, 3, 0, 0},
    parameter int unsigned CFG_BASE  [2**(RATE_W+1)] = '{0, 4, 8, 0, 12, 15, 0, 0},
    parameter int unsigned CFG_CNT   [2**(RATE_W+1)] = '{4, 4, 4, 0, 3, 3, 0, 0},
    parameter int unsigned FT_QGRP   [2]             = '{3, 2},
    parameter int unsigned ENT_GRP   [NENT] = '{0,0,1,1, 0,1,2,2, 0,1,2,3, 0,1,1, 0,1,2},
    parameter int unsigned ENT_SHIFT [NENT] = '{3,5,7,0, 1,6,2,4, 0,3,5,7, 2,4,6, 7,1,3},
    parameter int unsigned ENT_ADDR  [NENT] = '{0,2,1,0, 1,2,0,1, 0,1,2,0, 1,0,1, 0,1,0}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_bit,
    input  logic              in_vld,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_ftype,
    input  logic [RATE_W-1:0] in_rate,
    output logic              out_bit,
    output logic              out_vld,
    output logic              out_sof,
    output logic              out_eof,
    output logic              busy,
    output logic              cfg_err
);

    localparam int KG_W = (MAX_KGRP > 1) ? $clog2(MAX_KGRP) : 1;
    localparam int QG_W = (MAX_QGRP > 1) ? $clog2(MAX_QGRP) : 1;
    localparam int SH_W = (P > 1) ? $clog2(P) : 1;
    localparam int EN_W = (NENT > 1) ? $clog2(NENT) : 1;
    localparam logic [SH_W-1:0] POS_LAST = SH_W'(P - 1);
    localparam logic [KG_W:0]   KG_ONE   = 1;
    localparam logic [QG_W:0]   QG_ONE   = 1;
    localparam logic [EN_W:0]   EN_ONE   = 1;
    localparam logic [EN_W-1:0] EI_ONE   = 1;
    localparam logic [SH_W-1:0] SH_ONE   = 1;

    qc_state_e       state;
    logic [RATE_W:0] cap_ci;
    logic [RATE_W:0] tbl_ci;
    logic [KG_W:0]   wg;
    logic [SH_W-1:0] wb;
    logic [EN_W-1:0] ent_idx;
    logic [EN_W:0]   ent_left;
    logic [KG_W:0]   mg;
    logic [SH_W-1:0] mb;
    logic [QG_W-1:0] pw;
    logic [SH_W-1:0] pb;
    logic            in_par;
    logic            run;
    logic            first;
    qc_out_t         outr;
    logic            err_r;

    logic [KG_W:0]   kgrp;
    logic [QG_W:0]   qgrp;
    logic [EN_W-1:0] base;
    logic [EN_W:0]   cnt;
    logic [KG_W-1:0] e_grp;
    logic [SH_W-1:0] e_shift;
    logic [QG_W-1:0] e_addr;

    logic            start;
    logic            live_ok;
    logic            wr_en;
    logic [KG_W-1:0] wr_grp;
    logic [SH_W-1:0] wr_pos;
    logic [P-1:0]    grp_word;
    logic [P-1:0]    rot_word;
    logic            msg_bit;
    logic            par_bit;
    logic            acc_en;
    logic            par_clr;
    logic [KG_W:0]   kg_last;
    logic [QG_W:0]   qg_last;
    logic            cur_bit;

    assign start   = in_vld && in_sof;
    assign live_ok = qc_cfg_ok(in_ftype, 32'(in_rate), NRATE);
    assign tbl_ci  = (state == ST_IDLE) ? {in_ftype, in_rate} : cap_ci;
    assign kg_last = kgrp - KG_ONE;
    assign qg_last = qgrp - QG_ONE;

    qc_code_tables #(
        .RATE_W(RATE_W), .NENT(NENT), .KG_W(KG_W), .QG_W(QG_W),
        .SH_W(SH_W), .EN_W(EN_W),
        .CFG_KGRP(CFG_KGRP), .CFG_BASE(CFG_BASE), .CFG_CNT(CFG_CNT),
        .FT_QGRP(FT_QGRP), .ENT_GRP(ENT_GRP), .ENT_SHIFT(ENT_SHIFT),
        .ENT_ADDR(ENT_ADDR)
    ) u_tables (
        .cfg_idx(tbl_ci),
        .ent_idx(ent_idx),
        .kgrp(kgrp),
        .qgrp(qgrp),
        .base(base),
        .cnt(cnt),
        .e_grp(e_grp),
        .e_shift(e_shift),
        .e_addr(e_addr)
    );

    // Message write path: first bit in idle, the rest while loading
    always_comb begin
        wr_en  = 1'b0;
        wr_grp = '0;
        wr_pos = '0;
        if (state == ST_IDLE) begin
            wr_en = start && live_ok;
        end else if (state == ST_LOAD) begin
            wr_en  = in_vld && (wg < kgrp);
            wr_grp = wg[KG_W-1:0];
            wr_pos = wb;
        end
    end

    qc_msg_buffer #(
        .P(P), .MAX_KGRP(MAX_KGRP), .KG_W(KG_W), .SH_W(SH_W)
    ) u_msg (
        .clk(clk),
        .wr_en(wr_en),
        .wr_grp(wr_grp),
        .wr_pos(wr_pos),
        .wr_bit(in_bit),
        .grp_addr(e_grp),
        .grp_word(grp_word),
        .bit_grp(mg[KG_W-1:0]),
        .bit_pos(mb),
        .bit_out(msg_bit)
    );

    qc_rotator #(.P(P), .SH_W(SH_W)) u_rot (
        .din(grp_word),
        .shift(e_shift),
        .dout(rot_word)
    );

    assign acc_en  = (state == ST_ACC) && (ent_left != '0);
    assign par_clr = (state == ST_CLR);

    qc_parity_store #(
        .P(P), .MAX_QGRP(MAX_QGRP), .QG_W(QG_W), .SH_W(SH_W)
    ) u_par (
        .clk(clk),
        .rst(rst),
        .clr(par_clr),
        .acc_en(acc_en),
        .acc_addr(e_addr),
        .acc_data(rot_word),
        .rd_word(pw),
        .rd_pos(pb),
        .rd_bit(par_bit)
    );

    assign cur_bit = in_par ? (par_bit ^ run) : msg_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cap_ci   <= '0;
            wg       <= '0;
            wb       <= '0;
            ent_idx  <= '0;
            ent_left <= '0;
            mg       <= '0;
            mb       <= '0;
            pw       <= '0;
            pb       <= '0;
            in_par   <= 1'b0;
            run      <= 1'b0;
            first    <= 1'b0;
            outr     <= '0;
            err_r    <= 1'b0;
        end else begin
            outr  <= '0;
            err_r <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (live_ok) begin
                            cap_ci <= {in_ftype, in_rate};
                            wg     <= '0;
                            wb     <= SH_ONE;
                            state  <= ST_LOAD;
                        end else begin
                            err_r <= 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (in_vld) begin
                        if (wb == POS_LAST) begin
                            wb <= '0;
                            wg <= wg + KG_ONE;
                        end else begin
                            wb <= wb + SH_ONE;
                        end
                        if (in_eof) begin
                            state <= ST_CLR;
                        end
                    end
                end
                ST_CLR: begin
                    ent_idx  <= base;
                    ent_left <= cnt;
                    state    <= ST_ACC;
                end
                ST_ACC: begin
                    if (ent_left == '0) begin
                        mg     <= '0;
                        mb     <= '0;
                        pw     <= '0;
                        pb     <= '0;
                        in_par <= 1'b0;
                        run    <= 1'b0;
                        first  <= 1'b1;
                        state  <= ST_EMIT;
                    end else begin
                        ent_idx  <= ent_idx + EI_ONE;
                        ent_left <= ent_left - EN_ONE;
                    end
                end
                ST_EMIT: begin
                    first    <= 1'b0;
                    outr.vld <= 1'b1;
                    outr.sof <= first;
                    outr.dat <= cur_bit;
                    if (!in_par) begin
                        if (mb == POS_LAST) begin
                            mb <= '0;
                            mg <= mg + KG_ONE;
                            if (mg == kg_last) begin
                                in_par <= 1'b1;
                            end
                        end else begin
                            mb <= mb + SH_ONE;
                        end
                    end else begin
                        run <= cur_bit;
                        if ({1'b0, pw} == qg_last) begin
                            pw <= '0;
                            pb <= pb + SH_ONE;
                            if (pb == POS_LAST) begin
                                outr.eof <= 1'b1;
                                state    <= ST_IDLE;
                            end
                        end else begin
                            pw <= pw + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign out_bit = outr.dat;
    assign out_vld = outr.vld;
    assign out_sof = outr.sof;
    assign out_eof = outr.eof;
    assign busy    = (state != ST_IDLE);
    assign cfg_err = err_r;

    // R7
    sof_with_vld_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_vld);
    // R7
    eof_with_vld_chk: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_vld);
    // R9
    busy_covers_out_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_eof) |-> busy);
    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cap_ci));
    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> ($past(in_vld && in_sof) && !busy));
    // R2
    no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> !out_vld);

endmodule

// File: tb/qc_ldpc_encoder_test.sv
`timescale 1ns/1ps
module qc_ldpc_encoder_test;

    localparam int P = 8;
    localparam int ENT_G [18] = '{0,0,1,1, 0,1,2,2, 0,1,2,3, 0,1,1, 0,1,2};
    localparam int ENT_S [18] = '{3,5,7,0, 1,6,2,4, 0,3,5,7, 2,4,6, 7,1,3};
    localparam int ENT_A [18] = '{0,2,1,0, 1,2,0,1, 0,1,2,0, 1,0,1, 0,1,0};
    localparam int C_K   [8]  = '{2,3,4,0, 2,3,0,0};
    localparam int C_B   [8]  = '{0,4,8,0, 12,15,0,0};
    localparam int C_N   [8]  = '{4,4,4,0, 3,3,0,0};
    localparam int F_Q   [2]  = '{3,2};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_bit = 1'b0, in_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic       in_ftype = 1'b0;
    logic [1:0] in_rate = '0;
    logic       out_bit, out_vld, out_sof, out_eof, busy, cfg_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    bit sending = 0;
    bit early_out = 0;
    bit exp_q[$];
    int mon_idx = 0;
    int mon_n = 0;
    int mon_k = 0;

    always #10 clk = ~clk;

    qc_ldpc_encoder uut (
        .clk(clk), .rst(rst), .in_bit(in_bit), .in_vld(in_vld), .in_sof(in_sof),
        .in_eof(in_eof), .in_ftype(in_ftype), .in_rate(in_rate),
        .out_bit(out_bit), .out_vld(out_vld), .out_sof(out_sof), .out_eof(out_eof),
        .busy(busy), .cfg_err(cfg_err)
    );

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    // Output monitor: every valid bit is compared with the golden stream
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sending && out_vld) early_out = 1;
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "output with no frame pending", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    // R3, R4 and R5 govern the parity bits; R6 the message bits
                    chk(out_bit == e, (mon_idx < mon_k) ? "R6" : "R5", "codeword bit",
                        int'(out_bit), int'(e));
                    chk(out_sof == (mon_idx == 0), "R7", "sof position", int'(out_sof),
                        int'(mon_idx == 0));
                    chk(out_eof == (mon_idx == mon_n - 1), "R7", "eof position",
                        int'(out_eof), int'(mon_idx == mon_n - 1));
                    if (out_eof) chk(busy == 0, "R9", "busy at last bit", int'(busy), 0);
                    mon_idx++;
                end
            end else if (mon_idx > 0 && mon_idx < mon_n) begin
                chk(0, "R7", "gap in valid", 0, 1);
                mon_idx = mon_n;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_frame(int ft, int rt, int pat, bit poke);
        int cfg = ft * 4 + rt;
        int k = C_K[cfg] * P;
        int q = F_Q[ft];
        int np = q * P;
        bit msg[];
        bit acc[];
        bit r;
        msg = new[k];
        acc = new[np];
        for (int i = 0; i < k; i++) begin
            case (pat)
                0: msg[i] = 1'($urandom % 2);
                1: msg[i] = 1'b1;
                default: msg[i] = (i == k - 1);
            endcase
        end
        for (int j = 0; j < np; j++) acc[j] = 0;
        for (int e = C_B[cfg]; e < C_B[cfg] + C_N[cfg]; e++) begin
            for (int i = 0; i < P; i++) begin
                int dst = ((i + ENT_S[e]) % P) * q + ENT_A[e];
                acc[dst] ^= msg[ENT_G[e] * P + i];
            end
        end
        for (int i = 0; i < k; i++) exp_q.push_back(msg[i]);
        r = 0;
        for (int j = 0; j < np; j++) begin
            r ^= acc[j];
            exp_q.push_back(r);
        end
        mon_idx = 0;
        mon_n = k + np;
        mon_k = k;
        early_out = 0;
        sending = 1;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (i == 1) chk(busy == 1, "R9", "busy after accepted start", int'(busy), 1);
            in_vld = 1;
            in_sof = (i == 0);
            in_eof = (i == k - 1);
            in_bit = msg[i];
            // R1: after the first bit the frame/rate inputs wander
            in_ftype = (i == 0) ? 1'(ft) : ~1'(ft);
            in_rate  = (i == 0) ? 2'(rt) : 2'($urandom % 4);
        end
        @(negedge clk);
        sending = 0;
        in_vld = 0; in_sof = 0; in_eof = 0; in_bit = 0;
        chk(early_out == 0, "R2", "output before end strobe", int'(early_out), 0);
        if (poke) begin
            while (!out_vld) @(negedge clk);
            // R9: start while busy must be ignored
            in_vld = 1; in_sof = 1; in_eof = 1; in_ftype = 0; in_rate = 0; in_bit = 1;
            @(negedge clk);
            in_vld = 0; in_sof = 0; in_eof = 0; in_bit = 0;
        end
        while (exp_q.size() > 0 || busy) @(negedge clk);
        chk(mon_idx == mon_n, "R6", "codeword length", mon_idx, mon_n);
        repeat (12) @(negedge clk);
        chk(busy == 0, "R9", "idle after frame", int'(busy), 0);
    endtask

    task automatic bad_cfg(int ft, int rt);
        @(negedge clk);
        in_vld = 1; in_sof = 1; in_eof = 0; in_ftype = 1'(ft); in_rate = 2'(rt); in_bit = 1;
        @(negedge clk);
        in_vld = 0; in_sof = 0; in_bit = 0;
        chk(cfg_err == 1, "R10", "error pulse", int'(cfg_err), 1);
        chk(busy == 0, "R10", "busy on rejected start", int'(busy), 0);
        @(negedge clk);
        chk(cfg_err == 0, "R10", "error pulse width", int'(cfg_err), 0);
        repeat (20) @(negedge clk);
        chk(busy == 0, "R10", "still idle", int'(busy), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R11
        chk(out_vld == 0, "R11", "out_vld in reset", int'(out_vld), 0);
        chk(busy == 0, "R11", "busy in reset", int'(busy), 0);
        chk(cfg_err == 0, "R11", "cfg_err in reset", int'(cfg_err), 0);
        chk((out_sof | out_eof) == 0, "R11", "strobes in reset", int'(out_sof | out_eof), 0);
        rst = 0;
        repeat (3) @(negedge clk);
        run_frame(0, 0, 0, 0);
        run_frame(0, 1, 0, 0);
        run_frame(0, 2, 0, 1);
        run_frame(1, 0, 0, 0);
        run_frame(1, 1, 0, 1);
        run_frame(0, 0, 1, 0);
        // R8: an all-zero-parity-sensitive frame right after a dense one
        run_frame(0, 0, 2, 0);
        run_frame(0, 2, 2, 0);
        bad_cfg(1, 2);
        bad_cfg(0, 3);
        bad_cfg(1, 3);
        run_frame(1, 0, 1, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule